// File: doc/BRIEF.md
# Power-Good Forwarding Gate

This block sits between the board's power monitoring and the host chipset. It relays two power-status lines, and edges in opposite directions are treated differently. A rising edge on either line has to be earned: it is qualified by the state of the 5 V rail, or it is held back by a fixed delay. A falling edge always passes at once, because a lost supply must reach the chipset without delay.

The first path forwards the standby-reset line. A low-to-high change reaches the chipset only while the 5 V rail is both enabled and reporting good. The power-good pin of that rail alone cannot be trusted, because it floats high when its regulator has no supply. The second path copies the combined system power-good onto the chipset's power-ok line, but only while the host state shows fully on. Each rising edge on that path is delayed by a whole number of milliseconds, counted from a parameterised millisecond tick. The block also raises a request to drop to the off state when the reset input is lost while the host sits in standby.

Every input is asynchronous and passes through a two-flop synchroniser. The outputs are plain registered levels. There is no data stream, so there is no valid/ready handshake.

Top module: `pg_forward_gate`

## Requirements
- R1: With `rail_en` and `rail_good` both high, a rising edge on `rstb_in` appears on `rstb_out` at the third rising clock edge after the input changes. With either rail signal low, `rstb_out` stays low.
- R2: If `rstb_in` is already high while the rail is unqualified, `rstb_out` rises at the third edge after the later of `rail_en` and `rail_good` goes high.
- R3: A falling edge on `rstb_in` appears on `rstb_out` at the third edge, whatever the rail signals are doing.
- R4: Once `rstb_out` is high, later changes on `rail_en` or `rail_good` leave it high for as long as `rstb_in` stays high.
- R5: `pwr_ok` is high only while `host_state` is 2'b10 (fully on). The other codes are 2'b00 off, 2'b01 standby and 2'b11 transition. After `host_state` leaves 2'b10, `pwr_ok` falls at the third edge.
- R6: While on, `pwr_ok` rises at edge 2 + CYC_PER_MS*DELAY_MS after `sys_good` rises.
- R7: A falling edge on `sys_good` appears on `pwr_ok` at the third edge.
- R8: A high pulse on `sys_good` that lasts fewer than CYC_PER_MS*DELAY_MS cycles cancels the pending rise, and `pwr_ok` never goes high. A pulse of at least that length raises it.
- R9: `off_req` is high from the third edge after `host_state` is 2'b01 and `rstb_in` is low, and it is low otherwise.
- R10: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_state | input | 2 | Host power state: 00 off, 01 standby, 10 on, 11 transition |
| rail_en | input | 1 | 5 V rail enable as driven on the board |
| rail_good | input | 1 | 5 V rail power-good |
| rstb_in | input | 1 | Standby reset from the board sequencer |
| sys_good | input | 1 | Combined system power-good |
| rstb_out | output | 1 | Qualified standby reset to the chipset |
| pwr_ok | output | 1 | Delayed system power-ok to the chipset |
| off_req | output | 1 | Request to fall back to the off state |

## Verification
The situation that is hardest to bring about is a `sys_good` glitch that ends just before or just after the delay expires. From the ports this looks the same as a normal rise unless the pulse width is placed exactly. The bench therefore sweeps every pulse width from one cycle up to two cycles past the delay, with a small tick period. For each width it records whether `pwr_ok` ever went high and compares the result with width >= CYC_PER_MS*DELAY_MS. The reset path is swept over all four rail combinations for rising edges, falling edges and holding.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  typedef enum logic [1:0] {
    HS_OFF   = 2'b00,
    HS_STBY  = 2'b01,
    HS_ON    = 2'b10,
    HS_TRANS = 2'b11
  } host_state_e;
endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pgf_ms_tick.sv
module pgf_ms_tick #(
  parameter int CYC_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr||wrap) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign tick = wrap & ~clr;

  // A cleared divider starts a fresh millisecond, so the next cycle cannot tick.
  p_fresh_after_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && CYC_PER_MS > 1) |=> !tick);
endmodule

// File: rtl/pgf_rst_gate.sv
module pgf_rst_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_s,
  input  logic en_s,
  input  logic pg_s,
  output logic fwd
);
  logic qualified;
  assign qualified = en_s & pg_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fwd <= 1'b0;
    else        fwd <= rst_s & (fwd | qualified);
  end

  p_rise_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd) |-> $past(en_s && pg_s));
  p_fall_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_s |=> !fwd);
  p_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd && rst_s) |=> fwd);
endmodule

// File: rtl/pgf_pwrok_delay.sv
module pgf_pwrok_delay #(
  parameter int CYC_PER_MS = 50000,
  parameter int DELAY_MS   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_s,
  input  logic good_s,
  output logic ok
);
  localparam int DW = (DELAY_MS > 1) ? $clog2(DELAY_MS) : 1;
  localparam logic [DW-1:0] MS_LAST = DW'(DELAY_MS - 1);

  logic          arm;
  logic          tick;
  logic [DW-1:0] ms_cnt;

  assign arm = on_s & good_s;

  pgf_ms_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (~arm | ok),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok     <= 1'b0;
      ms_cnt <= '0;
    end else if (!arm) begin
      ok     <= 1'b0;
      ms_cnt <= '0;
    end else if (!ok && tick) begin
      if (ms_cnt == MS_LAST) begin
        ok     <= 1'b1;
        ms_cnt <= '0;
      end else begin
        ms_cnt <= ms_cnt + 1'b1;
      end
    end
  end

  p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> $past(tick && arm));
  p_drop_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !ok);
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm) |=> (ms_cnt == '0));
endmodule

// File: rtl/pg_forward_gate.sv
module pg_forward_gate
  import pgf_pkg::*;
#(
  parameter int CYC_PER_MS = 50000,
  parameter int DELAY_MS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] host_state,
  input  logic       rail_en,
  input  logic       rail_good,
  input  logic       rstb_in,
  input  logic       sys_good,
  output logic       rstb_out,
  output logic       pwr_ok,
  output logic       off_req
);
  localparam int NSIG = 6;

  logic [NSIG-1:0] raw, syn;
  host_state_e     state_s;
  logic            en_s, pg_s, rst_s, sys_s;

  assign raw = {host_state, rail_en, rail_good, rstb_in, sys_good};

  pgf_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw),
    .q    (syn)
  );

  assign state_s = host_state_e'(syn[5:4]);
  assign en_s    = syn[3];
  assign pg_s    = syn[2];
  assign rst_s   = syn[1];
  assign sys_s   = syn[0];

  pgf_rst_gate u_rst_gate (
    .clk  (clk),
    .rst_n(rst_n),
    .rst_s(rst_s),
    .en_s (en_s),
    .pg_s (pg_s),
    .fwd  (rstb_out)
  );

  pgf_pwrok_delay #(.CYC_PER_MS(CYC_PER_MS), .DELAY_MS(DELAY_MS)) u_pwrok (
    .clk   (clk),
    .rst_n (rst_n),
    .on_s  (state_s == HS_ON),
    .good_s(sys_s),
    .ok    (pwr_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_req <= 1'b0;
    else        off_req <= (state_s == HS_STBY) & ~rst_s;
  end

  p_on_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_s != HS_ON) |=> !pwr_ok);
  p_off_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_s == HS_STBY) && !rst_s) |=> off_req);
  p_off_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_s |=> !off_req);
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (!rstb_out && !pwr_ok && !off_req));
endmodule

// File: tb/pg_forward_gate_test.sv
module pg_forward_gate_test;
  localparam int CYC = 5;
  localparam int DMS = 2;
  localparam int N   = CYC * DMS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_state = 2'b00;
  logic       rail_en = 1'b0, rail_good = 1'b0, rstb_in = 1'b0, sys_good = 1'b0;
  logic       rstb_out, pwr_ok, off_req;

  int runs = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pg_forward_gate #(.CYC_PER_MS(CYC), .DELAY_MS(DMS)) uut (
    .clk(clk), .rst_n(rst_n), .host_state(host_state), .rail_en(rail_en),
    .rail_good(rail_good), .rstb_in(rstb_in), .sys_good(sys_good),
    .rstb_out(rstb_out), .pwr_ok(pwr_ok), .off_req(off_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    runs++;
    $display("FAIL watchdog: got hang expected finish");
    summary();
  end

  initial begin
    @(negedge clk);
    step(3);
    chk("R10 rstb_out", rstb_out, 1'b0);
    chk("R10 pwr_ok", pwr_ok, 1'b0);
    chk("R10 off_req", off_req, 1'b0);
    rst_n = 1'b1;
    step(4);

    // R1, R3: rising and falling reset edges under every rail combination
    for (int c = 0; c < 4; c++) begin
      rail_en = c[1]; rail_good = c[0];
      rstb_in = 1'b0; step(4);
      rstb_in = 1'b1; step(2);
      chk("R1 before latency", rstb_out, 1'b0);
      step(1);
      chk("R1 rise qualified", rstb_out, c[1] & c[0]);
      step(3);
      chk("R1 steady", rstb_out, c[1] & c[0]);
      rstb_in = 1'b0; step(2);
      chk("R3 before latency", rstb_out, c[1] & c[0]);
      step(1);
      chk("R3 fall passes", rstb_out, 1'b0);
    end

    // R3 with a rail that became unqualified after the rise
    rail_en = 1'b1; rail_good = 1'b1; rstb_in = 1'b1; step(5);
    rail_good = 1'b0; rail_en = 1'b0; step(1);
    rstb_in = 1'b0; step(3);
    chk("R3 fall with rail off", rstb_out, 1'b0);

    // R2: input high first, rail qualified later
    for (int c = 0; c < 3; c++) begin
      rail_en = c[1]; rail_good = c[0];
      rstb_in = 1'b1; step(6);
      chk("R2 held low", rstb_out, 1'b0);
      rail_en = 1'b1; rail_good = 1'b1; step(2);
      chk("R2 before latency", rstb_out, 1'b0);
      step(1);
      chk("R2 late qualify", rstb_out, 1'b1);
      // R4: rail changes after forwarding are ignored
      for (int d = 0; d < 4; d++) begin
        rail_en = d[1]; rail_good = d[0]; step(4);
        chk("R4 stays high", rstb_out, 1'b1);
      end
      rstb_in = 1'b0; step(4);
    end

    // R9: off request only in standby with the reset input low
    rstb_in = 1'b1;
    for (int s = 0; s < 4; s++) begin
      host_state = s[1:0]; rstb_in = 1'b1; step(4);
      chk("R9 clear with reset high", off_req, 1'b0);
      rstb_in = 1'b0; step(2);
      chk("R9 before latency", off_req, 1'b0);
      step(1);
      chk("R9 request", off_req, (s == 1));
      rstb_in = 1'b1; step(3);
      chk("R9 release", off_req, 1'b0);
    end

    // R5: power-ok only in the on state
    sys_good = 1'b1;
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      host_state = s[1:0]; step(N + 8);
      chk("R5 not on", pwr_ok, 1'b0);
    end

    // R6: delayed rise after the state becomes on
    host_state = 2'b10; step(N + 1);
    chk("R6 before delay", pwr_ok, 1'b0);
    step(1);
    chk("R6 after delay", pwr_ok, 1'b1);
    host_state = 2'b01; step(2);
    chk("R5 before latency", pwr_ok, 1'b1);
    step(1);
    chk("R5 leaves on", pwr_ok, 1'b0);

    // R6, R7: edges on sys_good while on
    host_state = 2'b10; sys_good = 1'b0; step(5);
    sys_good = 1'b1; step(N + 1);
    chk("R6 sys rise early", pwr_ok, 1'b0);
    step(1);
    chk("R6 sys rise", pwr_ok, 1'b1);
    sys_good = 1'b0; step(2);
    chk("R7 before latency", pwr_ok, 1'b1);
    step(1);
    chk("R7 fall", pwr_ok, 1'b0);

    // R8: sweep of pulse widths around the delay
    for (int w = 1; w <= N + 2; w++) begin
      logic seen;
      seen = 1'b0;
      sys_good = 1'b0; step(4);
      sys_good = 1'b1;
      for (int i = 0; i < w; i++) begin step(1); seen |= pwr_ok; end
      sys_good = 1'b0;
      for (int i = 0; i < N + 6; i++) begin step(1); seen |= pwr_ok; end
      chk("R8 pulse width", seen, (w >= N));
    end

    summary();
  end
endmodule